// File: doc/BRIEF.md
# Resolver converter configuration port

This block models the serial configuration port of a resolver-to-digital converter. It acts as an SPI slave in mode 3: the clock idles high, the slave drives MISO after each falling edge, and MOSI is sampled on each rising edge. The SPI pins, the two mode-select pins and a set of fault test inputs are oversampled in the system clock domain. Each 8-bit transfer is then handled as one unit. A byte with its top bit set names a register. A byte with its top bit clear is the value for the register named last. Whatever the named register holds is shifted out, most significant bit first, during the next transfer. A host reads a register by sending its address and then a filler byte of 0xFF in a second chip-select frame.

The port holds seven threshold registers, an excitation-frequency register and a control register. It also has a sticky fault register fed from test inputs, and a soft-reset command. The control register's low seven bits drive `cfg_ctrl`, which sets the converter's resolution code (bits 1:0), the resolution-enable bits (3:2), hysteresis (bit 4) and phase-lock range (bit 5). The SPI clock half-period must be at least six system clocks, and chip select must stay deasserted for at least eight system clocks between frames.

Top module: `rcfg_port`

## Requirements
- R1: After reset, `cfg_ctrl` is 0x7E, `miso` is 0, the fault register is 0x00, and a read of control (0x92) returns 0x7E.
- R2: A byte with bit 7 = 1 arms that address. A byte with bit 7 = 0 is written to the armed address and disarms it, so each address takes at most one data byte.
- R3: Data bytes write bits 6:0 to the thresholds (0x88 to 0x8E), the excitation register (0x91) and control (0x92). These registers read back with bit 7 = 0, and control changes only on an accepted data byte.
- R4: In the transfer after an address byte, `miso` carries that register's contents MSB first. Each bit is driven after a falling SCLK edge and is valid at the following rising edge.
- R5: A read of control returns an error flag in bit 7 above the stored bits 6:0. The flag is set by a data byte that arrives with no armed address, and cleared by a data write to control.
- R6: Address 0xF0 followed by data 0x00 sets control to 0x7E and clears the error flag. The threshold and excitation registers are left unchanged. Address 0xF0 followed by any nonzero data byte has no effect.
- R7: A byte completed while the mode pins are anything other than `sel_a0`=1, `sel_a1`=0 changes no register, and the next transfer shifts out 0x00.
- R8: Data bytes sent to position (0x80), velocity (0x82) or any other unlisted address are discarded. Reads of those addresses return 0x00.
- R9: The fault register (0xFF) collects the OR of `fault_in` over time. When it is loaded for shifting out, it restarts from the current `fault_in`, so a second read returns only faults that arrived in between.
- R10: `miso` is 0 while chip select is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock, idles high |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| sel_a0 | input | 1 | Mode select pin 0 (1 selects configuration) |
| sel_a1 | input | 1 | Mode select pin 1 (0 selects configuration) |
| fault_in | input | DW | Fault condition test inputs, OR-accumulated |
| cfg_ctrl | output | DW-1 | Stored control bits 6:0 |

## Verification
Two situations are the hardest to bring about from the ports. The first is a data byte that finds no armed address. Every read sends 0xFF, which re-arms the fault address, so an orphan byte only happens when a complete write is followed directly by a second data byte. The bench builds exactly that sequence and then checks bit 7 of the control read-back. The second is a byte that completes outside configuration mode. The mode pins are changed during the gap between frames, and the next frame's returned byte shows that the ignored address left only zeros for shifting out.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam logic [7:0] ADR_THR_LO = 8'h88;
  localparam logic [7:0] ADR_EXC    = 8'h91;
  localparam logic [7:0] ADR_CTRL   = 8'h92;
  localparam logic [7:0] ADR_SRST   = 8'hF0;
  localparam logic [7:0] ADR_FAULT  = 8'hFF;
  localparam logic [6:0] CTRL_DEF   = 7'h7E;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_MEM   = 2'd1,
    SRC_CTRL  = 2'd2,
    SRC_FAULT = 2'd3
  } rd_src_e;
endpackage

// File: rtl/rcfg_sync.sv
module rcfg_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= RST_VAL[i];
        q[i] <= RST_VAL[i];
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/rcfg_shift.sv
module rcfg_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          csn_s,
  input  logic          mosi_s,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_data,
  output logic          byte_vld,
  output logic [DW-1:0] byte_q,
  output logic          miso
);
  localparam int CW = $clog2(DW);

  logic          sclk_d;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] tx_sr;
  logic          rise, fall;

  assign rise = sclk_s & ~sclk_d & ~csn_s;
  assign fall = ~sclk_s & sclk_d & ~csn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      bcnt     <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      miso     <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      byte_vld <= 1'b0;
      if (csn_s) begin
        bcnt <= '0;
        miso <= 1'b0;
      end else begin
        if (rise) begin
          rx_sr <= {rx_sr[DW-2:0], mosi_s};
          if (bcnt == CW'(DW-1)) begin
            bcnt     <= '0;
            byte_vld <= 1'b1;
            byte_q   <= {rx_sr[DW-2:0], mosi_s};
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        if (fall) begin
          miso  <= tx_sr[DW-1];
          tx_sr <= {tx_sr[DW-2:0], 1'b0};
        end
      end
      if (tx_load) tx_sr <= tx_data;
    end
  end
endmodule

// File: rtl/rcfg_regs.sv
module rcfg_regs
  import rcfg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_q,
  input  logic          cfg_ok,
  input  logic [DW-1:0] fault_in,
  output logic          tx_load,
  output logic [DW-1:0] tx_data,
  output logic [DW-1:0] ctrl_q,
  output logic          arm_valid,
  output logic [DW-1:0] arm_addr
);
  localparam int MD = NT + 1;
  localparam int AW = $clog2(MD);

  function automatic logic in_mem(input logic [DW-1:0] a);
    return ((int'(a) >= int'(ADR_THR_LO)) && (int'(a) < int'(ADR_THR_LO) + NT))
           || (a == DW'(ADR_EXC));
  endfunction

  function automatic logic [AW-1:0] mem_idx(input logic [DW-1:0] a);
    if (a == DW'(ADR_EXC)) return AW'(NT);
    return AW'(int'(a) - int'(ADR_THR_LO));
  endfunction

  logic [DW-1:0] mem [MD];
  logic [DW-1:0] rd_q;
  logic [DW-2:0] ctrl;
  logic          err;
  logic [DW-1:0] fault_q;
  logic          ld_pend;
  rd_src_e       ld_src;
  logic          acc, is_addr, dwr, mem_we;
  rd_src_e       src_nxt;

  assign acc     = byte_vld & cfg_ok;
  assign is_addr = byte_q[DW-1];
  assign dwr     = acc & ~is_addr & arm_valid;
  assign mem_we  = dwr & in_mem(arm_addr);

  always_comb begin
    if (!acc || !is_addr)                 src_nxt = SRC_ZERO;
    else if (byte_q == DW'(ADR_FAULT))    src_nxt = SRC_FAULT;
    else if (byte_q == DW'(ADR_CTRL))     src_nxt = SRC_CTRL;
    else if (in_mem(byte_q))              src_nxt = SRC_MEM;
    else                                  src_nxt = SRC_ZERO;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_idx(arm_addr)] <= {1'b0, byte_q[DW-2:0]};
    rd_q <= mem[mem_idx(byte_q)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= CTRL_DEF;
      err       <= 1'b0;
      arm_valid <= 1'b0;
      arm_addr  <= '0;
      ld_pend   <= 1'b0;
      ld_src    <= SRC_ZERO;
      fault_q   <= '0;
    end else begin
      ld_pend <= byte_vld;
      if (byte_vld) ld_src <= src_nxt;
      if (ld_pend && ld_src == SRC_FAULT) fault_q <= fault_in;
      else                                fault_q <= fault_q | fault_in;
      if (acc) begin
        if (is_addr) begin
          arm_valid <= 1'b1;
          arm_addr  <= byte_q;
        end else if (arm_valid) begin
          arm_valid <= 1'b0;
          if (arm_addr == DW'(ADR_CTRL)) begin
            ctrl <= byte_q[DW-2:0];
            err  <= 1'b0;
          end else if (arm_addr == DW'(ADR_SRST) && byte_q == '0) begin
            ctrl <= CTRL_DEF;
            err  <= 1'b0;
          end
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  assign ctrl_q  = {err, ctrl};
  assign tx_load = ld_pend;

  always_comb begin
    case (ld_src)
      SRC_MEM:   tx_data = rd_q;
      SRC_CTRL:  tx_data = ctrl_q;
      SRC_FAULT: tx_data = fault_q;
      default:   tx_data = '0;
    endcase
  end
endmodule

// File: rtl/rcfg_port.sv
module rcfg_port
  import rcfg_pkg::*;
#(
  parameter int DW = 8,
  parameter int NT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  input  logic          sel_a0,
  input  logic          sel_a1,
  input  logic [DW-1:0] fault_in,
  output logic [DW-2:0] cfg_ctrl
);
  logic          sclk_s, csn_s, mosi_s, a0_s, a1_s, cfg_s;
  logic          byte_vld, tx_load, arm_valid;
  logic [DW-1:0] byte_q, tx_data, ctrl_full, arm_addr;

  rcfg_sync #(.N(5), .RST_VAL(5'b11000)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, cs_n, mosi, sel_a0, sel_a1}),
    .q   ({sclk_s, csn_s, mosi_s, a0_s, a1_s})
  );

  assign cfg_s = a0_s & ~a1_s;

  rcfg_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sclk_s),
    .csn_s    (csn_s),
    .mosi_s   (mosi_s),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .byte_vld (byte_vld),
    .byte_q   (byte_q),
    .miso     (miso)
  );

  rcfg_regs #(.DW(DW), .NT(NT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .byte_q    (byte_q),
    .cfg_ok    (cfg_s),
    .fault_in  (fault_in),
    .tx_load   (tx_load),
    .tx_data   (tx_data),
    .ctrl_q    (ctrl_full),
    .arm_valid (arm_valid),
    .arm_addr  (arm_addr)
  );

  assign cfg_ctrl = ctrl_full[DW-2:0];
endmodule

// File: rtl/rcfg_port_chk.sv
module rcfg_port_chk
  import rcfg_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          csn_s,
  input logic          miso,
  input logic          cfg_s,
  input logic          byte_vld,
  input logic [DW-1:0] byte_q,
  input logic [DW-1:0] ctrl_q,
  input logic          arm_valid,
  input logic [DW-1:0] arm_addr
);
  AST_IDLE_MISO: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !miso); // R10

  AST_IGNORED_BYTE: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !cfg_s) |=> $stable(ctrl_q)); // R7

  AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> $stable(ctrl_q)); // R3

  AST_SRST_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && cfg_s && byte_q == '0 && arm_valid && arm_addr == DW'(ADR_SRST))
    |=> ctrl_q == {1'b0, CTRL_DEF}); // R6

  AST_DATA_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && cfg_s && !byte_q[DW-1]) |=> !arm_valid); // R2

  AST_ADDR_ARMS: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && cfg_s && byte_q[DW-1]) |=> (arm_valid && arm_addr == $past(byte_q))); // R2
endmodule

bind rcfg_port rcfg_port_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .csn_s     (csn_s),
  .miso      (miso),
  .cfg_s     (cfg_s),
  .byte_vld  (byte_vld),
  .byte_q    (byte_q),
  .ctrl_q    (ctrl_full),
  .arm_valid (arm_valid),
  .arm_addr  (arm_addr)
);

// File: tb/rcfg_port_tb.sv
module rcfg_port_tb;
  localparam int DW = 8;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic sel_a0 = 1'b1, sel_a1 = 1'b0;
  logic [DW-1:0] fault_in = '0;
  logic miso;
  logic [DW-2:0] cfg_ctrl;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rcfg_port #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .sel_a0(sel_a0), .sel_a1(sel_a1), .fault_in(fault_in), .cfg_ctrl(cfg_ctrl)
  );

  // {address, data, expected read-back}
  localparam logic [23:0] VEC [13] = '{
    24'h88_15_15, 24'h8A_7F_7F, 24'h8E_2A_2A, 24'h91_28_28, 24'h8B_00_00,
    24'h8D_01_01, 24'h89_40_40, 24'h92_35_35, 24'h80_55_00, 24'h82_11_00,
    24'h8F_33_00, 24'h90_12_00, 24'hC4_66_00
  };

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    cs_n = 1'b0;
    wclk(4);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0;
      mosi = tx[i];
      wclk(H);
      rx[i] = miso;
      sclk = 1'b1;
      wclk(H);
    end
    cs_n = 1'b1;
    wclk(12);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] junk;
    spi_byte(a, junk);
    spi_byte(d, junk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] junk;
    spi_byte(a, junk);
    spi_byte(8'hFF, v);
  endtask

  initial begin
    logic [7:0] v;
    wclk(5);
    rst = 1'b0;
    wclk(3);
    // R1 reset state
    check("R1 cfg_ctrl", {1'b0, cfg_ctrl}, 8'h7E);
    check("R1 miso", {7'd0, miso}, 8'h00);
    rd(8'hFF, v); check("R1 fault", v, 8'h00);
    rd(8'h92, v); check("R1 ctrl read", v, 8'h7E);

    // R3 R4 R8 table of writes and read-backs
    for (int k = 0; k < 13; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], v);
      check((VEC[k][7:0] == 8'h00) ? "R8 discard" : "R3 R4 readback", v, VEC[k][7:0]);
    end
    check("R3 cfg_ctrl", {1'b0, cfg_ctrl}, 8'h35);

    // R10 miso low between frames after reading a byte whose LSB is 1
    rd(8'h92, v);
    check("R10 idle miso", {7'd0, miso}, 8'h00);

    // R2 R5 orphan data byte
    wr(8'h92, 8'h35);
    spi_byte(8'h22, v);
    check("R2 orphan ignored", {1'b0, cfg_ctrl}, 8'h35);
    rd(8'h92, v); check("R5 error flag", v, 8'hB5);
    wr(8'h92, 8'h35);
    rd(8'h92, v); check("R5 flag cleared", v, 8'h35);

    // R6 soft reset
    wr(8'hF0, 8'h05);
    check("R6 nonzero no effect", {1'b0, cfg_ctrl}, 8'h35);
    wr(8'hF0, 8'h00);
    check("R6 ctrl default", {1'b0, cfg_ctrl}, 8'h7E);
    rd(8'h88, v); check("R6 threshold kept", v, 8'h15);
    rd(8'h91, v); check("R6 excitation kept", v, 8'h28);

    // R7 mode gating
    sel_a0 = 1'b0; sel_a1 = 1'b0; wclk(4);
    wr(8'h92, 8'h11);
    check("R7 mode 00", {1'b0, cfg_ctrl}, 8'h7E);
    sel_a0 = 1'b1; sel_a1 = 1'b1; wclk(4);
    wr(8'h8A, 8'h03);
    spi_byte(8'h92, v);
    sel_a0 = 1'b1; sel_a1 = 1'b0; wclk(4);
    spi_byte(8'hFF, v); check("R7 ignored byte gives zero", v, 8'h00);
    rd(8'h8A, v); check("R7 threshold kept", v, 8'h7F);
    rd(8'h92, v); check("R7 ctrl read", v, 8'h7E);

    // R9 fault accumulation and restart
    fault_in = 8'h05; wclk(3); fault_in = 8'h00; wclk(3);
    fault_in = 8'h20; wclk(3); fault_in = 8'h00; wclk(3);
    spi_byte(8'hFF, v);
    spi_byte(8'hFF, v); check("R9 accumulated", v, 8'h25);
    spi_byte(8'hFF, v); check("R9 cleared", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule